// File: doc/BRIEF.md
# Multi-Queue Packet FIFO

This block holds several independent first-in first-out queues in one shared storage array. Each queue owns a fixed power-of-two slice of the array, and the queue index forms the upper address bits. A write port and a read port each keep a registered queue selection, which is changed by a load strobe. An accepted read returns the word one clock later and marks it with a valid strobe. Each queue shows its own full and empty flag. A write to a full queue and a read from an empty queue have no effect.

In packet mode, two in-band marker bits of each 36-bit word delimit packets: bit 32 opens a packet and bit 33 closes one. Each queue counts the complete packets it holds. An active-low packet-ready output reports whether the queue selected for reading holds at least one such packet. The write selection may not leave a queue while a packet is still open there. Such an attempt is refused and reported. Packet mode is captured only while the master reset is held, and only a 36-bit build can enable it. A partial reset pulse empties a single queue. It takes effect only when that queue has been selected on both ports for at least two clock edges.

Top module: `mq_pkt_fifo`

## Requirements
- R1: An accepted read (rd_en high, selected read queue not empty) drives rd_valid high on the next clock, with rd_data equal to the oldest word of that queue. Each queue keeps its own write order.
- R2: full[q] is high exactly when queue q holds QDEPTH words, and empty[q] is high exactly when it holds none. After master reset all queues are empty, no queue is full, and queue 0 is selected on both ports.
- R3: A write while the selected write queue is full is dropped. A read while the selected read queue is empty gives rd_valid low and leaves the queue unchanged.
- R4: Packet mode is taken from pkt_mode_in only while rst_n is low, and later changes of pkt_mode_in have no effect. With WIDTH other than 36, packet mode stays off and pkt_ready_n stays high.
- R5: In packet mode, bit WIDTH-4 (bit 32) of a written word is the start marker and bit WIDTH-3 (bit 33) is the end marker. A queue's complete-packet count rises by one when a word carrying an end marker is accepted for writing. It falls by one when such a word is read out.
- R6: pkt_ready_n is low exactly when packet mode is on and the queue selected for reading holds at least one complete packet.
- R7: In packet mode, a write-queue load while the current write queue has an open packet is refused. A start marker opens a packet and an end marker closes it, and a word carrying both leaves none open. A refused load keeps the old queue and pulses switch_err high for one cycle. Outside packet mode every load is accepted and switch_err stays low.
- R8: A queue load takes effect at the clock edge that samples it. A read or write on that same edge still uses the previous queue.
- R9: prst_n sampled low acts only when the write and read selections are equal and neither has been loaded within the last clock edge. Loading at edge k allows a reset at edge k+2 onward. The reset empties that queue and clears its packet count and open-packet state, and packet mode is unchanged.
- R10: prst_n sampled low without that condition has no effect on any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, active low |
| pkt_mode_in | input | 1 | Packet mode request, captured during master reset |
| wr_qload | input | 1 | Load wr_qsel as the write queue |
| wr_qsel | input | $clog2(NQ) | Write queue index |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| rd_qload | input | 1 | Load rd_qsel as the read queue |
| rd_qsel | input | $clog2(NQ) | Read queue index |
| rd_en | input | 1 | Read request |
| prst_n | input | 1 | Partial reset of the selected queue, active low |
| rd_data | output | WIDTH | Read word, registered |
| rd_valid | output | 1 | rd_data carries a word read on the previous edge |
| full | output | NQ | Per-queue full flags |
| empty | output | NQ | Per-queue empty flags |
| pkt_ready_n | output | 1 | Low when the read queue holds a complete packet |
| switch_err | output | 1 | One-cycle pulse on a refused write-queue load |

## Verification
The bench builds the main instance at WIDTH=36 with four queues of only four words each. Full queues, dropped writes and packet counts near the queue depth therefore come up often under random traffic with frequent queue loads and partial resets. A second instance at WIDTH=16 has its mode input tied high, which makes the refusal of packet mode on narrow builds visible at its ready output. The main instance is run once with packet mode latched on and once with it latched off, while pkt_mode_in keeps toggling after reset.

// File: rtl/mq_pkt_fifo.sv
module mq_pkt_fifo #(
  parameter int WIDTH  = 36,
  parameter int NQ     = 4,
  parameter int QDEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_mode_in,
  input  logic                  wr_qload,
  input  logic [$clog2(NQ)-1:0] wr_qsel,
  input  logic                  wr_en,
  input  logic [WIDTH-1:0]      wr_data,
  input  logic                  rd_qload,
  input  logic [$clog2(NQ)-1:0] rd_qsel,
  input  logic                  rd_en,
  input  logic                  prst_n,
  output logic [WIDTH-1:0]      rd_data,
  output logic                  rd_valid,
  output logic [NQ-1:0]         full,
  output logic [NQ-1:0]         empty,
  output logic                  pkt_ready_n,
  output logic                  switch_err
);
  localparam int QSW    = $clog2(NQ);
  localparam int QAW    = $clog2(QDEPTH);
  localparam int CW     = QAW + 1;
  localparam int SOP    = WIDTH - 4;
  localparam int EOP    = WIDTH - 3;
  localparam bit PKT_OK = (WIDTH == 36);

  logic [WIDTH-1:0] mem [NQ*QDEPTH];
  logic [QAW-1:0]   wptr [NQ];
  logic [QAW-1:0]   rptr [NQ];
  logic [CW-1:0]    cnt  [NQ];
  logic [CW-1:0]    pcnt [NQ];
  logic             in_pkt [NQ];
  logic [QSW-1:0]   wr_q, rd_q;
  logic [1:0]       age;
  logic             pkt_mode;

  logic             prst_hit, do_wr, do_rd, sw_block, sw_take;
  logic             wr_sop, wr_eop, rd_eop;
  logic [WIDTH-1:0] rd_word;

  assign prst_hit = !prst_n && (wr_q == rd_q) && (age == 2'd2);
  assign do_wr    = wr_en && !full[wr_q] && !prst_hit;
  assign do_rd    = rd_en && !empty[rd_q] && !prst_hit;
  assign rd_word  = mem[{rd_q, rptr[rd_q]}];
  assign wr_sop   = pkt_mode && wr_data[SOP];
  assign wr_eop   = pkt_mode && wr_data[EOP];
  assign rd_eop   = pkt_mode && rd_word[EOP];
  assign sw_block = pkt_mode && in_pkt[wr_q];
  assign sw_take  = wr_qload && !sw_block;
  assign pkt_ready_n = !(pkt_mode && (pcnt[rd_q] != '0));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic wsel, rsel, clr;
    assign wsel = do_wr && (wr_q == QSW'(q));
    assign rsel = do_rd && (rd_q == QSW'(q));
    assign clr  = prst_hit && (wr_q == QSW'(q));
    assign full[q]  = (cnt[q] == CW'(QDEPTH));
    assign empty[q] = (cnt[q] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wptr[q]   <= '0;
        rptr[q]   <= '0;
        cnt[q]    <= '0;
        pcnt[q]   <= '0;
        in_pkt[q] <= 1'b0;
      end else if (clr) begin
        wptr[q]   <= '0;
        rptr[q]   <= '0;
        cnt[q]    <= '0;
        pcnt[q]   <= '0;
        in_pkt[q] <= 1'b0;
      end else begin
        if (wsel) wptr[q] <= wptr[q] + 1'b1;
        if (rsel) rptr[q] <= rptr[q] + 1'b1;
        cnt[q]  <= cnt[q] + CW'(wsel) - CW'(rsel);
        pcnt[q] <= pcnt[q] + CW'(wsel && wr_eop) - CW'(rsel && rd_eop);
        if (wsel && wr_sop) in_pkt[q] <= 1'b1;
        if (wsel && wr_eop) in_pkt[q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[{wr_q, wptr[wr_q]}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pkt_mode <= pkt_mode_in && PKT_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= '0;
      rd_q       <= '0;
      age        <= 2'd0;
      switch_err <= 1'b0;
    end else begin
      switch_err <= wr_qload && sw_block;
      if (sw_take)  wr_q <= wr_qsel;
      if (rd_qload) rd_q <= rd_qsel;
      if (sw_take || rd_qload) age <= 2'd1;
      else if (age != 2'd2)    age <= age + 2'd1;
    end
  end
endmodule

// File: rtl/mq_pkt_fifo_chk.sv
module mq_pkt_fifo_chk #(
  parameter int NQ = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  prst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  wr_qload,
  input logic [NQ-1:0]         full,
  input logic [NQ-1:0]         empty,
  input logic                  rd_valid,
  input logic                  pkt_ready_n,
  input logic                  switch_err,
  input logic                  pkt_mode,
  input logic [$clog2(NQ)-1:0] wr_q,
  input logic [$clog2(NQ)-1:0] rd_q,
  input logic [1:0]            age
);
  // R3
  rd_empty_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty[rd_q]) |=> !rd_valid);

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty[rd_q] && prst_n) |=> rd_valid);

  // R3
  wr_full_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full[wr_q] && !rd_en && prst_n) |=> full[$past(wr_q)]);

  // R6
  pkt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready_n |-> (pkt_mode && !empty[rd_q]));

  // R7
  switch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_err |-> ($past(wr_qload) && pkt_mode && $stable(wr_q)));

  // R9
  prst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prst_n && (wr_q == rd_q) && (age == 2'd2)) |=> empty[$past(rd_q)]);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(pkt_mode));
endmodule

bind mq_pkt_fifo mq_pkt_fifo_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .wr_en(wr_en), .rd_en(rd_en),
  .wr_qload(wr_qload), .full(full), .empty(empty), .rd_valid(rd_valid),
  .pkt_ready_n(pkt_ready_n), .switch_err(switch_err), .pkt_mode(pkt_mode),
  .wr_q(wr_q), .rd_q(rd_q), .age(age)
);

// File: tb/tb_mq_pkt_fifo.sv
`timescale 1ns/1ps
module tb_mq_pkt_fifo;
  localparam int W = 36, NQ = 4, D = 4;

  logic clk = 0, rst_n = 0, pkt_mode_in = 0;
  logic wr_qload = 0, wr_en = 0, rd_qload = 0, rd_en = 0, prst_n = 1;
  logic [1:0] wr_qsel = 0, rd_qsel = 0;
  logic [W-1:0] wr_data = 0, rd_data;
  logic rd_valid, pkt_ready_n, switch_err;
  logic [NQ-1:0] full, empty;

  logic n_wr_en = 0;
  logic [15:0] n_wr_data = 0, n_rd_data;
  logic n_rd_valid, n_prdy, n_err;
  logic [NQ-1:0] n_full, n_empty;

  always #10 clk = ~clk;

  mq_pkt_fifo #(.WIDTH(W), .NQ(NQ), .QDEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_mode_in(pkt_mode_in), .wr_qload(wr_qload),
    .wr_qsel(wr_qsel), .wr_en(wr_en), .wr_data(wr_data), .rd_qload(rd_qload),
    .rd_qsel(rd_qsel), .rd_en(rd_en), .prst_n(prst_n), .rd_data(rd_data),
    .rd_valid(rd_valid), .full(full), .empty(empty), .pkt_ready_n(pkt_ready_n),
    .switch_err(switch_err));

  mq_pkt_fifo #(.WIDTH(16), .NQ(NQ), .QDEPTH(D)) dut_n (
    .clk(clk), .rst_n(rst_n), .pkt_mode_in(1'b1), .wr_qload(1'b0),
    .wr_qsel(2'd0), .wr_en(n_wr_en), .wr_data(n_wr_data), .rd_qload(1'b0),
    .rd_qsel(2'd0), .rd_en(1'b0), .prst_n(1'b1), .rd_data(n_rd_data),
    .rd_valid(n_rd_valid), .full(n_full), .empty(n_empty), .pkt_ready_n(n_prdy),
    .switch_err(n_err));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] mdl [NQ][$];
  int mpc [NQ];
  bit mopen [NQ];
  int mwq, mrq, mage;
  bit mmode, ev, eerr;
  logic [W-1:0] ed;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; wr_qload = 0; rd_qload = 0; prst_n = 1; n_wr_en = 0;
  endtask

  task automatic step();
    bit hit, dw, dr, blk, take;
    logic [W-1:0] w;
    @(posedge clk);
    hit  = !prst_n && mwq == mrq && mage == 2;
    dw   = wr_en && mdl[mwq].size() < D && !hit;
    dr   = rd_en && mdl[mrq].size() > 0 && !hit;
    blk  = mmode && mopen[mwq];
    ev = dr;
    if (dr) begin
      w = mdl[mrq].pop_front(); ed = w;
      if (mmode && w[33]) mpc[mrq]--;
    end
    if (dw) begin
      mdl[mwq].push_back(wr_data);
      if (mmode) begin
        if (wr_data[32]) mopen[mwq] = 1;
        if (wr_data[33]) begin mopen[mwq] = 0; mpc[mwq]++; end
      end
    end
    if (hit) begin mdl[mwq].delete(); mpc[mwq] = 0; mopen[mwq] = 0; end
    eerr = wr_qload && blk;
    take = wr_qload && !blk;
    if (take) mwq = int'(wr_qsel);
    if (rd_qload) mrq = int'(rd_qsel);
    mage = (take || rd_qload) ? 1 : (mage < 2 ? mage + 1 : 2);
    @(negedge clk);
    chk("R1 valid", rd_valid, ev);
    if (ev) chk("R1 data", rd_data, ed);
    for (int q = 0; q < NQ; q++) begin
      chk("R2 full", full[q], mdl[q].size() == D);
      chk("R2 empty", empty[q], mdl[q].size() == 0);
    end
    chk("R6 ready", pkt_ready_n, !(mmode && mpc[mrq] > 0));
    chk("R7 err", switch_err, eerr);
  endtask

  task automatic do_reset(bit m);
    idle(); rst_n = 0; pkt_mode_in = m;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int q = 0; q < NQ; q++) begin mdl[q].delete(); mpc[q] = 0; mopen[q] = 0; end
    mwq = 0; mrq = 0; mage = 0; mmode = m; ev = 0; eerr = 0;
    chk("R2 reset empty", empty, 4'hF);
    chk("R2 reset full", full, 4'h0);
    chk("R1 reset valid", rd_valid, 0);
    chk("R6 reset ready", pkt_ready_n, 1);
  endtask

  task automatic wr1(logic [3:0] top, logic [31:0] lo);
    idle(); wr_en = 1; wr_data = {top, lo}; step();
  endtask

  task automatic rnd_cycle();
    int r;
    idle();
    wr_en = $urandom_range(0, 9) < 6;
    rd_en = $urandom_range(0, 9) < 5;
    r = $urandom_range(0, 9);
    wr_data = {2'($urandom), (r < 2) ? 2'b01 : (r < 4) ? 2'b10 : (r == 4) ? 2'b11 : 2'b00,
               32'($urandom)};
    wr_qload = $urandom_range(0, 99) < 8;  wr_qsel = 2'($urandom);
    rd_qload = $urandom_range(0, 99) < 8;  rd_qsel = 2'($urandom);
    prst_n = !($urandom_range(0, 99) < 3);
    pkt_mode_in = 1'($urandom);
    step();
  endtask

  initial begin
    void'($urandom(32'd7321));
    do_reset(1);

    for (int i = 0; i < 5; i++) wr1(4'h0, 32'h100 + i);
    chk("R3 full after extra write", full[0], 1);
    for (int i = 0; i < 5; i++) begin
      idle(); rd_en = 1; step();
      if (i == 4) chk("R3 empty read", rd_valid, 0);
    end
    chk("R3 queue empty", empty[0], 1);

    idle(); n_wr_en = 1; n_wr_data = 16'h3000; @(posedge clk); @(negedge clk); n_wr_en = 0;
    chk("R4 narrow build", n_prdy, 1);

    idle(); wr_qload = 1; wr_qsel = 1; rd_qload = 1; rd_qsel = 1; step();
    wr1(4'b0001, 32'hA0); wr1(4'b0000, 32'hA1); wr1(4'b0010, 32'hA2);
    chk("R6 packet ready", pkt_ready_n, 0);
    wr1(4'b0011, 32'hB0);
    for (int i = 0; i < 3; i++) begin idle(); rd_en = 1; step(); end
    chk("R5 one packet left", pkt_ready_n, 0);
    idle(); rd_en = 1; step();
    chk("R5 no packet left", pkt_ready_n, 1);

    idle(); wr_qload = 1; wr_qsel = 2; step();
    wr1(4'b0001, 32'hC0);
    idle(); wr_qload = 1; wr_qsel = 3; step();
    chk("R7 refused switch", switch_err, 1);
    wr1(4'b0010, 32'hC1);
    idle(); wr_qload = 1; wr_qsel = 0; step();
    chk("R7 allowed switch", switch_err, 0);

    wr1(4'h0, 32'hAAAA);
    idle(); wr_qload = 1; wr_qsel = 1; rd_qload = 1; rd_qsel = 0; step();
    wr1(4'h0, 32'hBBBB);
    idle(); rd_en = 1; rd_qload = 1; rd_qsel = 1; step();
    chk("R8 old queue read", rd_data, {4'h0, 32'hAAAA});
    idle(); rd_en = 1; step();
    chk("R8 new queue read", rd_data, {4'h0, 32'hBBBB});

    idle(); wr_qload = 1; wr_qsel = 3; rd_qload = 1; rd_qsel = 3; step();
    wr1(4'h0, 32'hD0); wr1(4'h0, 32'hD1);
    idle(); rd_qload = 1; rd_qsel = 3; step();
    idle(); prst_n = 0; step();
    chk("R10 early reset ignored", empty[3], 0);
    idle(); prst_n = 0; step();
    chk("R9 queue cleared", empty[3], 1);
    wr1(4'b0011, 32'hE0);
    chk("R9 mode kept", pkt_ready_n, 0);

    for (int i = 0; i < 3000; i++) rnd_cycle();

    do_reset(0);
    wr1(4'b0010, 32'hF0);
    chk("R4 plain mode", pkt_ready_n, 1);
    wr1(4'b0001, 32'hF1);
    idle(); wr_qload = 1; wr_qsel = 2; step();
    chk("R7 plain switch", switch_err, 0);
    for (int i = 0; i < 1500; i++) rnd_cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule